// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the register file that software and a 64-channel DMA engine share. Software reaches it over a simple word bus with byte enables. The engine reports events to it on dedicated strobes. The bank holds five per-channel bitmaps:

- request enable
- error-interrupt enable
- interrupt request
- error flag
- done

Each bitmap is split into a high word (channels 63..32) and a low word (channels 31..0). The bank also holds a control word, a packed error status word and one priority byte per channel. It combines the flags into a single interrupt line.

Eight byte-wide command registers let software change one channel's bit without a read-modify-write. Software writes a channel number into the command byte, and only that channel's bit in the chosen bitmap is set or cleared. A command byte with bit 6 set acts on every channel. A command byte with bit 7 set does nothing. The set-start command does not touch a bitmap. Instead it sends a one-cycle start pulse to the engine for the named channel.

Top module: `dma_chan_regbank`

## Requirements
- R1: After reset the following all read zero: every bitmap word, the control word, the error status word and every priority byte. `irq_o` is low.
- R2: Command bytes sit at offsets 0x18..0x1F, with byte lane = offset mod 4.
  - 0x18: set request enable.
  - 0x19: clear request enable.
  - 0x1A: set error-interrupt enable.
  - 0x1B: clear error-interrupt enable.
  - 0x1C: clear interrupt request.
  - 0x1D: clear error.
  - 0x1E: set start.
  - 0x1F: clear done.
  - A command byte with bits 7:6 = 00 acts only on the channel in bits 5:0.
- R3: A command byte with bit 6 set (bit 7 clear) acts on all 64 channels. A command byte with bit 7 set changes nothing.
- R4: The interrupt request words (0x20 high, 0x24 low) and error words (0x28 high, 0x2C low) are write-one-to-clear. Writing zero bits leaves those flags unchanged.
- R5: An engine error event does two things. It sets that channel's error bit. It loads the error status word (0x04) with the following fields:
  - bit 31: valid = 1.
  - bits 15 and 14: cause bits 9 and 8.
  - bits 13:8: the channel number.
  - bits 7:0: cause bits 7:0.
  - Reading the error status word does not change it. Clearing error flags does not change it either.
- R6: `irq_o` is high when any interrupt-request bit is set. It is also high when any error bit is set whose error-interrupt enable bit is also set.
- R7: A set-start command makes `start_o` carry that channel's bit for exactly the one cycle after the write.
- R8: The control word (0x00) keeps only bits 31, 3 and 2. All other bits read zero.
- R9: Channel c's priority byte lives at byte offset 0x100+c, in lane c mod 4. A write changes only the lanes whose byte enable is set.
- R10: If an engine event sets a bit in the same cycle as a clear command for that bit, the bit ends set.
- R11: A major-complete event sets the channel's interrupt-request bit. A done event sets the channel's done bit. The done words (0x30 high, 0x34 low) are read-only and are cleared only by the clear-done command.
- R12: Word writes to 0x08 (high) and 0x0C (low) load the request-enable bitmap. This bitmap is driven on `req_en_o`. Word writes to 0x10 and 0x14 load the error-interrupt enable bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 9 | Byte address; bits 1:0 are ignored for word decode |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; lane n carries bits 8n+7:8n |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_major_v | input | 1 | Engine: major loop complete |
| evt_major_ch | input | 6 | Channel of the major-complete event |
| evt_err_v | input | 1 | Engine: error detected |
| evt_err_ch | input | 6 | Channel of the error event |
| evt_err_cause | input | 10 | Cause bits of the error event |
| evt_done_v | input | 1 | Engine: channel done |
| evt_done_ch | input | 6 | Channel of the done event |
| req_en_o | output | 64 | Request-enable bitmap |
| start_o | output | 64 | One-cycle start pulses |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check several properties on every cycle:
- A start pulse only ever follows a set-start write.
- The error status word holds still unless an error event arrives.
- Every error event leaves the valid bit and the channel's error flag set.
- A major-complete event always leaves its bit set, even against a clear command.
- An ignored command byte leaves the request-enable bitmap unchanged.
- The interrupt only rises after a bus write or an engine event.

Some behaviour only the bench scenarios can show:
- The exact bit positions and lane mapping of each command.
- The packed error status layout.
- The broadcast and ignore encodings.
- The write-one-to-clear semantics.
- The way the interrupt follows the error-interrupt enables.

// File: rtl/dmacr_pkg.sv
// Shared definitions for the DMA channel register bank.
// Assumes a 32-bit register bus and byte offsets as listed below.
package dmacr_pkg;

    typedef enum logic [1:0] {
        BM_RW  = 2'd0,   // word write loads the bits
        BM_W1C = 2'd1,   // word write clears the bits written as one
        BM_RO  = 2'd2    // word writes ignored
    } bm_mode_e;

    localparam int OFS_CTRL    = 'h000;
    localparam int OFS_ERRSTAT = 'h004;
    localparam int OFS_REQ_HI  = 'h008;
    localparam int OFS_REQ_LO  = 'h00C;
    localparam int OFS_EEI_HI  = 'h010;
    localparam int OFS_EEI_LO  = 'h014;
    localparam int OFS_CMD     = 'h018;
    localparam int OFS_INT_HI  = 'h020;
    localparam int OFS_INT_LO  = 'h024;
    localparam int OFS_ERR_HI  = 'h028;
    localparam int OFS_ERR_LO  = 'h02C;
    localparam int OFS_DONE_HI = 'h030;
    localparam int OFS_DONE_LO = 'h034;
    localparam int OFS_PRIO    = 'h100;

    localparam int NUM_CMD = 8;
    localparam int CMD_SET_REQ = 0;
    localparam int CMD_CLR_REQ = 1;
    localparam int CMD_SET_EEI = 2;
    localparam int CMD_CLR_EEI = 3;
    localparam int CMD_CLR_INT = 4;
    localparam int CMD_CLR_ERR = 5;
    localparam int CMD_START   = 6;
    localparam int CMD_CLR_DONE = 7;

    localparam logic [31:0] CTRL_MASK = 32'h8000_000C;

    // Packs an error event into the status word layout.
    function automatic logic [31:0] pack_errstat(input logic [5:0] ch, input logic [9:0] cause);
        logic [31:0] w;
        w        = '0;
        w[31]    = 1'b1;
        w[15:14] = cause[9:8];
        w[13:8]  = ch;
        w[7:0]   = cause[7:0];
        return w;
    endfunction

endpackage

// File: rtl/dmacr_cmd_dec.sv
// Decodes one byte-wide channel command into a per-channel mask.
// Bit 7 set: no effect. Bit 6 set: all channels. Otherwise bits CH_W-1:0 name one channel.
// Assumes NUM_CH <= 64 so the channel number fits in bits 5:0.
module dmacr_cmd_dec #(
    parameter int NUM_CH = 64,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              fire,
    input  logic [7:0]        cmd,
    output logic [NUM_CH-1:0] mask
);
    // One comparator per channel: broadcast or index match.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign mask[i] = fire & ~cmd[7] & (cmd[6] | (cmd[CH_W-1:0] == CH_W'(i)));
    end
endmodule

// File: rtl/dmacr_bitmap.sv
// One per-channel bitmap split into 32-bit words (word 0 = low channels).
// Applies, in order: word write (per MODE), command set/clear, engine event set.
// Engine events therefore win over a same-cycle clear.
module dmacr_bitmap
    import dmacr_pkg::*;
#(
    parameter int       NUM_CH = 64,
    parameter bm_mode_e MODE   = BM_RW,
    localparam int      WORDS  = NUM_CH / 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORDS-1:0]  wr_word,
    input  logic [31:0]       wdata,
    input  logic [NUM_CH-1:0] cmd_set,
    input  logic [NUM_CH-1:0] cmd_clr,
    input  logic [NUM_CH-1:0] evt_set,
    output logic [NUM_CH-1:0] q
);
    logic [NUM_CH-1:0] nxt;

    // Next-state: bus word access, then commands, then engine events.
    always_comb begin
        nxt = q;
        for (int w = 0; w < WORDS; w++) begin
            if (wr_word[w]) begin
                case (MODE)
                    BM_RW:   nxt[w*32 +: 32] = wdata;
                    BM_W1C:  nxt[w*32 +: 32] = nxt[w*32 +: 32] & ~wdata;
                    default: nxt[w*32 +: 32] = nxt[w*32 +: 32];
                endcase
            end
        end
        nxt = ((nxt | cmd_set) & ~cmd_clr) | evt_set;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/dma_chan_regbank.sv
// Control and status register bank for a 64-channel DMA engine.
// Holds five channel bitmaps, a control word, a packed error status word and
// per-channel priority bytes; byte-wide commands set or clear single channels.
// Assumes NUM_CH = 64 (high/low word split) and one bus access per cycle.
module dma_chan_regbank
    import dmacr_pkg::*;
#(
    parameter int  NUM_CH = 64,
    parameter int  ADDR_W = 9,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int WORDS  = NUM_CH / 32,
    localparam int WA_W   = ADDR_W - 2,
    localparam int PRIO_W = NUM_CH / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    input  logic              evt_major_v,
    input  logic [CH_W-1:0]   evt_major_ch,
    input  logic              evt_err_v,
    input  logic [CH_W-1:0]   evt_err_ch,
    input  logic [9:0]        evt_err_cause,
    input  logic              evt_done_v,
    input  logic [CH_W-1:0]   evt_done_ch,
    output logic [NUM_CH-1:0] req_en_o,
    output logic [NUM_CH-1:0] start_o,
    output logic              irq_o
);
    function automatic logic [WA_W-1:0] wofs(input int b);
        return WA_W'(b >> 2);
    endfunction

    logic [WA_W-1:0]   wa;
    logic [NUM_CH-1:0] cmd_mask [NUM_CMD];
    logic [NUM_CH-1:0] maj_m, err_m, done_m;
    logic [NUM_CH-1:0] req_q, eei_q, int_q, err_q, done_q, start_q;
    logic [31:0]       ctrl_q, errstat_q;
    logic [7:0]        prio_q [NUM_CH];

    assign wa = bus_addr[ADDR_W-1:2];

    // Command lanes: two words of four byte-wide commands.
    for (genvar k = 0; k < NUM_CMD; k++) begin : g_cmd
        dmacr_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
            .fire (bus_wr && wa == wofs(OFS_CMD + 4*(k/4)) && bus_be[k%4]),
            .cmd  (bus_wdata[8*(k%4) +: 8]),
            .mask (cmd_mask[k])
        );
    end

    // Engine events expanded to one-hot channel masks.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_evt
        assign maj_m[i]  = evt_major_v && evt_major_ch == CH_W'(i);
        assign err_m[i]  = evt_err_v   && evt_err_ch   == CH_W'(i);
        assign done_m[i] = evt_done_v  && evt_done_ch  == CH_W'(i);
    end

    dmacr_bitmap #(.NUM_CH(NUM_CH), .MODE(BM_RW)) u_req (
        .clk, .rst_n,
        .wr_word ({bus_wr && wa == wofs(OFS_REQ_HI), bus_wr && wa == wofs(OFS_REQ_LO)}),
        .wdata (bus_wdata), .cmd_set (cmd_mask[CMD_SET_REQ]), .cmd_clr (cmd_mask[CMD_CLR_REQ]),
        .evt_set ('0), .q (req_q));

    dmacr_bitmap #(.NUM_CH(NUM_CH), .MODE(BM_RW)) u_eei (
        .clk, .rst_n,
        .wr_word ({bus_wr && wa == wofs(OFS_EEI_HI), bus_wr && wa == wofs(OFS_EEI_LO)}),
        .wdata (bus_wdata), .cmd_set (cmd_mask[CMD_SET_EEI]), .cmd_clr (cmd_mask[CMD_CLR_EEI]),
        .evt_set ('0), .q (eei_q));

    dmacr_bitmap #(.NUM_CH(NUM_CH), .MODE(BM_W1C)) u_int (
        .clk, .rst_n,
        .wr_word ({bus_wr && wa == wofs(OFS_INT_HI), bus_wr && wa == wofs(OFS_INT_LO)}),
        .wdata (bus_wdata), .cmd_set ('0), .cmd_clr (cmd_mask[CMD_CLR_INT]),
        .evt_set (maj_m), .q (int_q));

    dmacr_bitmap #(.NUM_CH(NUM_CH), .MODE(BM_W1C)) u_err (
        .clk, .rst_n,
        .wr_word ({bus_wr && wa == wofs(OFS_ERR_HI), bus_wr && wa == wofs(OFS_ERR_LO)}),
        .wdata (bus_wdata), .cmd_set ('0), .cmd_clr (cmd_mask[CMD_CLR_ERR]),
        .evt_set (err_m), .q (err_q));

    dmacr_bitmap #(.NUM_CH(NUM_CH), .MODE(BM_RO)) u_done (
        .clk, .rst_n, .wr_word ('0),
        .wdata (bus_wdata), .cmd_set ('0), .cmd_clr (cmd_mask[CMD_CLR_DONE]),
        .evt_set (done_m), .q (done_q));

    // Control word, error status capture and start pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            errstat_q <= '0;
            start_q   <= '0;
        end else begin
            if (bus_wr && wa == wofs(OFS_CTRL)) ctrl_q <= bus_wdata & CTRL_MASK;
            if (evt_err_v) errstat_q <= pack_errstat(6'(evt_err_ch), evt_err_cause);
            start_q <= cmd_mask[CMD_START];
        end
    end

    // Priority bytes: one register per channel, written by its byte lane.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n) prio_q[i] <= '0;
            else if (bus_wr && wa == wofs(OFS_PRIO + i) && bus_be[i%4])
                prio_q[i] <= bus_wdata[8*(i%4) +: 8];
        end
    end

    // Read multiplexer keyed on the word address.
    always_comb begin
        bus_rdata = '0;
        case (wa)
            wofs(OFS_CTRL):    bus_rdata = ctrl_q;
            wofs(OFS_ERRSTAT): bus_rdata = errstat_q;
            wofs(OFS_REQ_HI):  bus_rdata = req_q[63:32];
            wofs(OFS_REQ_LO):  bus_rdata = req_q[31:0];
            wofs(OFS_EEI_HI):  bus_rdata = eei_q[63:32];
            wofs(OFS_EEI_LO):  bus_rdata = eei_q[31:0];
            wofs(OFS_INT_HI):  bus_rdata = int_q[63:32];
            wofs(OFS_INT_LO):  bus_rdata = int_q[31:0];
            wofs(OFS_ERR_HI):  bus_rdata = err_q[63:32];
            wofs(OFS_ERR_LO):  bus_rdata = err_q[31:0];
            wofs(OFS_DONE_HI): bus_rdata = done_q[63:32];
            wofs(OFS_DONE_LO): bus_rdata = done_q[31:0];
            default: begin
                for (int j = 0; j < PRIO_W; j++)
                    if (wa == wofs(OFS_PRIO + 4*j))
                        bus_rdata = {prio_q[4*j+3], prio_q[4*j+2], prio_q[4*j+1], prio_q[4*j]};
            end
        endcase
    end

    assign req_en_o = req_q;
    assign start_o  = start_q;
    assign irq_o    = (|int_q) | (|(err_q & eei_q));

    // ---------------- assertions ----------------
    AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o != '0) |-> $past(bus_wr && wa == wofs(OFS_CMD + 4) && bus_be[2])); // R7

    AST_ERRSTAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_err_v |=> $stable(errstat_q)); // R5

    AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err_v |=> errstat_q[31] && err_q[$past(evt_err_ch)]); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_major_v |=> int_q[$past(evt_major_ch)]); // R10

    AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wa == wofs(OFS_CMD) && bus_be == 4'b0001 && bus_wdata[7]) |=> $stable(req_q)); // R3

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(bus_wr || evt_major_v || evt_err_v)); // R6

endmodule

// File: tb/sim_dma_chan_regbank.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module sim_dma_chan_regbank;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        evt_major_v = 0, evt_err_v = 0, evt_done_v = 0;
    logic [5:0]  evt_major_ch = '0, evt_err_ch = '0, evt_done_ch = '0;
    logic [9:0]  evt_err_cause = '0;
    logic [63:0] req_en_o, start_o;
    logic        irq_o;

    always #4 clk = ~clk;   // 125 MHz

    dma_chan_regbank u0 (.*);

    typedef struct { int sel; logic [63:0] exp; string tag; } item_t;
    item_t sb[$];
    int vectors = 0;
    int miscompares = 0;
    bit done_flag = 0;

    // Monitor: one expected item per cycle, sampled just after the edge.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (sb.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sb.pop_front();
                case (it.sel)
                    0: act = {32'b0, bus_rdata};
                    1: act = {63'b0, irq_o};
                    2: act = start_o;
                    default: act = req_en_o;
                endcase
                vectors++;
                if (act !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1; bus_addr = 9'(a); bus_wdata = d; bus_be = be;
        @(posedge clk); #2;
        bus_wr = 0; bus_be = '0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = 9'(a);
        sb.push_back('{0, {32'b0, e}, tag});
        @(posedge clk); #2;
    endtask

    task automatic chk(input int sel, input logic [63:0] e, input string tag);
        @(negedge clk);
        sb.push_back('{sel, e, tag});
        @(posedge clk); #2;
    endtask

    task automatic cmd(input int off, input logic [7:0] v);
        wr(off & ~3, 32'(v) << (8*(off%4)), 4'b0001 << (off%4));
    endtask

    task automatic ev_major(input logic [5:0] ch);
        @(negedge clk); evt_major_v = 1; evt_major_ch = ch;
        @(posedge clk); #2; evt_major_v = 0;
    endtask

    task automatic ev_err(input logic [5:0] ch, input logic [9:0] c);
        @(negedge clk); evt_err_v = 1; evt_err_ch = ch; evt_err_cause = c;
        @(posedge clk); #2; evt_err_v = 0;
    endtask

    task automatic ev_done(input logic [5:0] ch);
        @(negedge clk); evt_done_v = 1; evt_done_ch = ch;
        @(posedge clk); #2; evt_done_v = 0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R1 reset state
        rd('h00, 0, "R1 ctrl");
        rd('h04, 0, "R1 errstat");
        rd('h0C, 0, "R1 req lo");
        rd('h24, 0, "R1 int lo");
        rd('h30, 0, "R1 done hi");
        rd('h13C, 0, "R1 prio");
        chk(1, 0, "R1 irq");

        // R2 single-channel commands
        cmd('h18, 8'd5);
        rd('h0C, 32'h20, "R2 set req ch5");
        cmd('h18, 8'd40);
        rd('h08, 32'h100, "R2 set req ch40");
        cmd('h1A, 8'd3);
        rd('h14, 32'h8, "R2 set eei ch3");
        cmd('h19, 8'd5);
        rd('h0C, 0, "R2 clr req ch5");
        rd('h08, 32'h100, "R2 ch40 untouched");

        // R3 ignore and broadcast
        cmd('h18, 8'h85);
        rd('h0C, 0, "R3 bit7 ignored lo");
        rd('h08, 32'h100, "R3 bit7 ignored hi");
        cmd('h18, 8'h40);
        rd('h0C, 32'hFFFF_FFFF, "R3 broadcast set lo");
        rd('h08, 32'hFFFF_FFFF, "R3 broadcast set hi");
        cmd('h19, 8'h40);
        chk(3, 0, "R3 broadcast clear");

        // R11 + R6 + R4: major event, irq, write-one-to-clear
        ev_major(6'd2);
        rd('h24, 32'h4, "R11 major sets int");
        chk(1, 1, "R6 irq from int");
        wr('h24, 32'h0, 4'hF);
        rd('h24, 32'h4, "R4 zero write keeps");
        wr('h24, 32'h4, 4'hF);
        rd('h24, 0, "R4 w1c clears");
        chk(1, 0, "R6 irq cleared");

        // R5 error capture
        ev_err(6'd3, 10'b10_0000_0101);
        rd('h04, 32'h8000_8305, "R5 errstat pack");
        rd('h2C, 32'h8, "R5 err bit");
        chk(1, 1, "R6 irq err enabled");
        rd('h04, 32'h8000_8305, "R5 read no clear");
        cmd('h1D, 8'd3);
        rd('h2C, 0, "R2 clr err");
        rd('h04, 32'h8000_8305, "R5 kept after clr");
        chk(1, 0, "R6 irq off");
        ev_err(6'd50, 10'b01_1000_0000);
        rd('h04, 32'h8000_7280, "R5 errstat ch50");
        rd('h28, 32'h0004_0000, "R5 err hi");
        chk(1, 0, "R6 masked err no irq");
        wr('h28, 32'hFFFF_FFFF, 4'hF);
        rd('h28, 0, "R4 w1c all");

        // R11 done
        ev_done(6'd33);
        rd('h30, 32'h2, "R11 done set");
        wr('h30, 32'hFFFF_FFFF, 4'hF);
        rd('h30, 32'h2, "R11 done read-only");
        cmd('h1F, 8'd33);
        rd('h30, 0, "R11 clear done");

        // R7 start pulse
        @(negedge clk);
        bus_wr = 1; bus_addr = 9'h1C; bus_wdata = 32'(9) << 16; bus_be = 4'b0100;
        sb.push_back('{2, 64'h200, "R7 start pulse"});
        @(posedge clk); #2; bus_wr = 0; bus_be = '0;
        chk(2, 0, "R7 pulse one cycle");

        // R8 control mask
        wr('h00, 32'hFFFF_FFFF, 4'hF);
        rd('h00, 32'h8000_000C, "R8 ctrl mask");

        // R9 priority bytes
        wr('h104, 32'h4433_2211, 4'hF);
        rd('h104, 32'h4433_2211, "R9 prio word");
        wr('h104, 32'h0000_AA00, 4'b0010);
        rd('h104, 32'h4433_AA11, "R9 lane write");
        wr('h13C, 32'h7F00_0000, 4'b1000);
        rd('h13C, 32'h7F00_0000, "R9 ch63");

        // R10 event wins over clear
        @(negedge clk);
        bus_wr = 1; bus_addr = 9'h1C; bus_wdata = 32'd7; bus_be = 4'b0001;
        evt_major_v = 1; evt_major_ch = 6'd7;
        @(posedge clk); #2; bus_wr = 0; bus_be = '0; evt_major_v = 0;
        rd('h24, 32'h80, "R10 event wins");
        cmd('h1C, 8'd7);
        rd('h24, 0, "R10 later clear");

        // R12 word writes to enables
        wr('h0C, 32'h0000_1234, 4'hF);
        wr('h08, 32'h8000_0001, 4'hF);
        chk(3, 64'h8000_0001_0000_1234, "R12 req_en_o");
        wr('h10, 32'h0000_0010, 4'hF);
        rd('h10, 32'h10, "R12 eei hi");

        repeat (3) @(posedge clk);
        done_flag = 1;
        summary();
    end
endmodule